// File: doc/BRIEF.md
# Data-Memory Stage with Load-Use Interlock

This block is the memory stage of a five-stage pipeline for a small 32-bit load/store instruction set. Instruction and data storage are separate, so fetch never contends with the data memory. The block takes the contents of the execute/memory pipeline register: a valid bit, the primary opcode, a base register value, a 16-bit offset, store data, an ALU result, a destination register and a write-enable. It computes the effective address and accesses a word-wide synchronous data RAM held inside the block. It registers the result into the memory/writeback pipeline register.

The block also holds the interlock for the pipeline. It compares the instruction in execute against the instruction waiting in decode. When a word load is about to produce a register that the decoded instruction reads, it raises `stall`, which freezes the PC and the fetch/decode register, and `bubble`, which tells the surrounding pipeline to load a no-op into the decode/execute register. When decode holds a branch or jump, the held fetch register keeps the delay-slot instruction in place, so that instruction still runs after the stall ends.

Top module: `loadUseMemStage`

## Requirements
- R1: While `rstN` is low and after it rises, `memwbValid`, `memwbRegWrite`, `memwbDest` and `memwbData` are all zero until the first valid operation is registered.
- R2: The effective address is `exmemBase` plus `exmemOffset` sign-extended to 32 bits. The RAM word index is the address shifted right by two and truncated to the RAM index width, so the two low address bits are ignored.
- R3: A valid store (opcode 101011) writes `exmemStoreData` into the addressed word at the clock edge that ends its memory cycle. The registered result of a store has `memwbRegWrite` low.
- R4: A valid load (opcode 100011) places the addressed word in `memwbData` at the next edge. A load in the cycle right after a store to the same word returns the stored word.
- R5: Any other valid opcode passes `exmemAluResult` to `memwbData`, with `memwbRegWrite` equal to `exmemRegWrite`. Destination register 0 forces `memwbRegWrite` low for every opcode.
- R6: When `exmemValid` is low, the RAM is not written and `memwbValid` and `memwbRegWrite` are registered low.
- R7: `stall` is high when all of the following hold: execute holds a valid load with a nonzero destination, decode is valid, and that destination equals the decode rs field (bits 25:21). Every decode opcode reads rs except 000010, 000011 and 001111.
- R8: The decode rt field (bits 20:16) is compared only for opcode 000000 with function codes other than 001000 and 001001, and for opcodes 000100, 000101 and 101011.
- R9: A load with destination 0, a non-load in execute, or an invalid execute or decode slot never raises `stall`.
- R10: `bubble` equals `stall` in every cycle. Once the injected no-op reaches execute, `stall` drops, so one load-use pair costs exactly one bubble. A branch in decode that depends on the load is held in decode together with its delay-slot instruction in fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| exmemValid | input | 1 | Execute/memory register holds an instruction |
| exmemOp | input | 6 | Primary opcode in memory stage |
| exmemBase | input | 32 | Base register value |
| exmemOffset | input | 16 | Signed address offset |
| exmemStoreData | input | 32 | rt value for a store |
| exmemAluResult | input | 32 | Result of a non-memory instruction |
| exmemDest | input | 5 | Destination register |
| exmemRegWrite | input | 1 | Non-memory instruction writes a register |
| idexValid | input | 1 | Decode/execute register holds an instruction |
| idexOp | input | 6 | Primary opcode in execute |
| idexDest | input | 5 | Destination of the instruction in execute |
| ifidValid | input | 1 | Fetch/decode register holds an instruction |
| ifidInstr | input | 32 | Instruction word in decode |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load a no-op into decode/execute |
| memwbValid | output | 1 | Memory/writeback register valid |
| memwbRegWrite | output | 1 | Writeback enable |
| memwbDest | output | 5 | Writeback register |
| memwbData | output | 32 | Loaded word or passed ALU result |

## Verification
The hardest case to create from the ports is a full load-use episode. This needs a load in execute and a dependent instruction in decode in the same cycle, then a no-op replacing the load in execute while decode stays frozen, then the load reaching the memory stage with the right address. The bench plays the surrounding pipeline registers cycle by cycle: it advances or holds its own fetch, decode and execute slots according to `stall`. It counts the bubbles and adds the loaded word to a second operand to form the dependent sum. The same replay is run with a dependent branch in decode, to confirm that the delay-slot word stays in fetch. Random traffic over a small address window then produces frequent store-then-load collisions on the same word.

// File: rtl/memHazPkg.sv
package memHazPkg;
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_J       = 6'b000010;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] OP_LUI     = 6'b001111;
  localparam logic [5:0] OP_LW      = 6'b100011;
  localparam logic [5:0] OP_SW      = 6'b101011;
  localparam logic [5:0] FN_JR      = 6'b001000;
  localparam logic [5:0] FN_JALR    = 6'b001001;

  typedef struct packed {
    logic stall;
    logic bubble;
    logic memRead;
    logic memWrite;
    logic regWrite;
  } memStrobes_t;
endpackage

// File: rtl/hazardCtrl.sv
module hazardCtrl
  import memHazPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        idexValid,
  input  logic [5:0]  idexOp,
  input  logic [4:0]  idexDest,
  input  logic        ifidValid,
  input  logic [31:0] ifidInstr,
  input  logic        exmemValid,
  input  logic [5:0]  exmemOp,
  input  logic [4:0]  exmemDest,
  input  logic        exmemRegWrite,
  output memStrobes_t strobes
);
  logic [5:0] decOp;
  logic [5:0] decFn;
  logic [4:0] decRs;
  logic [4:0] decRt;
  logic       readsRs;
  logic       readsRt;
  logic       exIsLoad;
  logic       hazard;
  logic       memIsLoad;
  logic       memIsStore;

  always_comb begin
    decOp = 6'(ifidInstr >> 26);
    decRs = 5'(ifidInstr >> 21);
    decRt = 5'(ifidInstr >> 16);
    decFn = 6'(ifidInstr);
    readsRs = !(decOp == OP_J || decOp == OP_JAL || decOp == OP_LUI);
    readsRt = (decOp == OP_SPECIAL && decFn != FN_JR && decFn != FN_JALR)
           || decOp == OP_BEQ || decOp == OP_BNE || decOp == OP_SW;
    exIsLoad = idexValid && idexOp == OP_LW && idexDest != 5'd0;
    hazard = exIsLoad && ifidValid &&
             ((readsRs && decRs == idexDest) || (readsRt && decRt == idexDest));
  end

  always_comb begin
    memIsLoad  = exmemValid && exmemOp == OP_LW;
    memIsStore = exmemValid && exmemOp == OP_SW;
    strobes.stall    = hazard;
    strobes.bubble   = hazard;
    strobes.memRead  = memIsLoad;
    strobes.memWrite = memIsStore;
    strobes.regWrite = exmemValid && exmemDest != 5'd0 &&
                       (memIsLoad || (!memIsStore && exmemRegWrite));
  end

  // R9
  stall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |-> (idexValid && idexOp == OP_LW && idexDest != 5'd0 && ifidValid));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exmemValid |-> !(strobes.memWrite || strobes.memRead || strobes.regWrite));
endmodule

// File: rtl/memDatapath.sv
module memDatapath
  import memHazPkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic              exmemValid,
  input  logic [DATA_W-1:0] exmemBase,
  input  logic [15:0]       exmemOffset,
  input  logic [DATA_W-1:0] exmemStoreData,
  input  logic [DATA_W-1:0] exmemAluResult,
  input  logic [4:0]        exmemDest,
  output logic              memwbValid,
  output logic              memwbRegWrite,
  output logic [4:0]        memwbDest,
  output logic [DATA_W-1:0] memwbData
);
  localparam int IDX_W = $clog2(DEPTH_WORDS);

  logic [DATA_W-1:0] ram [DEPTH_WORDS];
  logic [DATA_W-1:0] effAddr;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] resultData;

  always_comb begin
    effAddr    = exmemBase + DATA_W'({{16{exmemOffset[15]}}, exmemOffset});
    wordIdx    = IDX_W'(effAddr >> 2);
    readWord   = ram[wordIdx];
    resultData = strobes.memRead ? readWord : exmemAluResult;
  end

  always_ff @(posedge clk) begin
    if (strobes.memWrite) ram[wordIdx] <= exmemStoreData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memwbValid    <= 1'b0;
      memwbRegWrite <= 1'b0;
      memwbDest     <= 5'd0;
      memwbData     <= '0;
    end else begin
      memwbValid    <= exmemValid;
      memwbRegWrite <= strobes.regWrite;
      memwbDest     <= exmemDest;
      memwbData     <= resultData;
    end
  end

  // R3
  store_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWrite |=> ram[$past(wordIdx)] == $past(exmemStoreData));

  // R3
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWrite |=> !memwbRegWrite);

  // R5
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    memwbRegWrite |-> (memwbDest != 5'd0 && memwbValid));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    memwbValid |-> $past(exmemValid));
endmodule

// File: rtl/loadUseMemStage.sv
module loadUseMemStage
  import memHazPkg::*;
#(
  parameter int DEPTH_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        exmemValid,
  input  logic [5:0]  exmemOp,
  input  logic [31:0] exmemBase,
  input  logic [15:0] exmemOffset,
  input  logic [31:0] exmemStoreData,
  input  logic [31:0] exmemAluResult,
  input  logic [4:0]  exmemDest,
  input  logic        exmemRegWrite,
  input  logic        idexValid,
  input  logic [5:0]  idexOp,
  input  logic [4:0]  idexDest,
  input  logic        ifidValid,
  input  logic [31:0] ifidInstr,
  output logic        stall,
  output logic        bubble,
  output logic        memwbValid,
  output logic        memwbRegWrite,
  output logic [4:0]  memwbDest,
  output logic [31:0] memwbData
);
  memStrobes_t strobes;

  hazardCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .idexValid(idexValid), .idexOp(idexOp), .idexDest(idexDest),
    .ifidValid(ifidValid), .ifidInstr(ifidInstr),
    .exmemValid(exmemValid), .exmemOp(exmemOp), .exmemDest(exmemDest),
    .exmemRegWrite(exmemRegWrite),
    .strobes(strobes)
  );

  memDatapath #(.DEPTH_WORDS(DEPTH_WORDS), .DATA_W(32)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .exmemValid(exmemValid), .exmemBase(exmemBase), .exmemOffset(exmemOffset),
    .exmemStoreData(exmemStoreData), .exmemAluResult(exmemAluResult),
    .exmemDest(exmemDest),
    .memwbValid(memwbValid), .memwbRegWrite(memwbRegWrite),
    .memwbDest(memwbDest), .memwbData(memwbData)
  );

  assign stall  = strobes.stall;
  assign bubble = strobes.bubble;
endmodule

// File: tb/tb_loadUseMemStage.sv
module tb_loadUseMemStage;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rstN;
  logic        exmemValid;
  logic [5:0]  exmemOp;
  logic [31:0] exmemBase;
  logic [15:0] exmemOffset;
  logic [31:0] exmemStoreData;
  logic [31:0] exmemAluResult;
  logic [4:0]  exmemDest;
  logic        exmemRegWrite;
  logic        idexValid;
  logic [5:0]  idexOp;
  logic [4:0]  idexDest;
  logic        ifidValid;
  logic [31:0] ifidInstr;
  logic        stall, bubble, memwbValid, memwbRegWrite;
  logic [4:0]  memwbDest;
  logic [31:0] memwbData;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  loadUseMemStage #(.DEPTH_WORDS(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int idxOf(logic [31:0] b, logic [15:0] o);
    logic [31:0] a;
    a = b + {{16{o[15]}}, o};
    return int'(a[9:2]);
  endfunction

  function automatic bit expStall(bit iv, logic [5:0] iop, logic [4:0] idst, bit fv, logic [31:0] ins);
    logic [5:0] op, fn;
    logic [4:0] rs, rt;
    bit uRs, uRt;
    op = ins[31:26]; fn = ins[5:0]; rs = ins[25:21]; rt = ins[20:16];
    uRs = !(op == 6'd2 || op == 6'd3 || op == 6'd15);
    uRt = (op == 6'd0 && fn != 6'd8 && fn != 6'd9) || op == 6'd4 || op == 6'd5 || op == 6'd43;
    return iv && fv && iop == 6'd35 && idst != 0 && ((uRs && rs == idst) || (uRt && rt == idst));
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleAll();
    exmemValid = 0; exmemOp = 0; exmemBase = 0; exmemOffset = 0;
    exmemStoreData = 0; exmemAluResult = 0; exmemDest = 0; exmemRegWrite = 0;
    idexValid = 0; idexOp = 0; idexDest = 0; ifidValid = 0; ifidInstr = 0;
  endtask

  task automatic setMem(bit v, logic [5:0] op, logic [31:0] b, logic [15:0] o,
                        logic [31:0] sd, logic [31:0] alu, logic [4:0] d, bit rw);
    exmemValid = v; exmemOp = op; exmemBase = b; exmemOffset = o;
    exmemStoreData = sd; exmemAluResult = alu; exmemDest = d; exmemRegWrite = rw;
  endtask

  // Drive one memory-stage op, clock it, check MEM/WB against the model.
  task automatic memOp(bit v, logic [5:0] op, logic [31:0] b, logic [15:0] o,
                       logic [31:0] sd, logic [31:0] alu, logic [4:0] d, bit rw, string req);
    int ix;
    logic [31:0] expData;
    bit expRw;
    setMem(v, op, b, o, sd, alu, d, rw);
    ix = idxOf(b, o);
    expData = (op == 6'd35) ? model[ix] : alu;
    expRw = v && d != 0 && (op == 6'd35 || (op != 6'd43 && rw));
    step();
    if (v && op == 6'd43) model[ix] = sd;
    chk(memwbValid == v, req, {31'd0, memwbValid}, {31'd0, v});
    chk(memwbRegWrite == expRw, req, {31'd0, memwbRegWrite}, {31'd0, expRw});
    if (v) begin
      chk(memwbData == expData, req, memwbData, expData);
      chk(memwbDest == d, req, {27'd0, memwbDest}, {27'd0, d});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idleAll();
    rstN = 0;
    @(negedge clk);
    // R1 reset state
    chk(memwbValid == 0 && memwbRegWrite == 0 && memwbDest == 0 && memwbData == 0,
        "R1", memwbData, 0);
    chk(stall == 0, "R1", {31'd0, stall}, 0);
    step();
    rstN = 1;
    step();
    chk(memwbValid == 0 && memwbData == 0, "R1", memwbData, 0);

    // R3 fill every word with known data
    for (int i = 0; i < DEPTH; i++)
      memOp(1, 6'd43, 32'(i * 4), 16'd0, $urandom, 32'h0, 5'd3, 1, "R3");

    // R2 negative offset, low bits ignored
    memOp(1, 6'd43, 32'h100, 16'hFFFC, 32'hCAFE0001, 0, 5'd0, 0, "R2");
    memOp(1, 6'd35, 32'h0FE, 16'h0000, 0, 0, 5'd9, 0, "R2");
    chk(memwbData == 32'hCAFE0001, "R2", memwbData, 32'hCAFE0001);
    // R4 store then load at once from same word
    memOp(1, 6'd43, 32'h40, 16'h0008, 32'h12345678, 0, 5'd0, 0, "R4");
    memOp(1, 6'd35, 32'h48, 16'h0000, 0, 0, 5'd12, 0, "R4");
    chk(memwbData == 32'h12345678, "R4", memwbData, 32'h12345678);
    // R5 passthrough and dest zero
    memOp(1, 6'd0, 0, 0, 0, 32'hA5A5A5A5, 5'd7, 1, "R5");
    memOp(1, 6'd8, 0, 0, 0, 32'h5, 5'd0, 1, "R5");
    memOp(1, 6'd35, 32'h48, 0, 0, 0, 5'd0, 0, "R5");
    // R6 invalid slot: no write
    memOp(0, 6'd43, 32'h48, 0, 32'hDEADDEAD, 0, 5'd4, 1, "R6");
    memOp(1, 6'd35, 32'h48, 0, 0, 0, 5'd4, 0, "R6");
    chk(memwbData == 32'h12345678, "R6", memwbData, 32'h12345678);

    // R10 load-use: LW r5,8(r1) in EX, ADD r6,r5,r7 in decode
    begin
      int bubbles = 0;
      logic [31:0] r7 = 32'd1000;
      logic [31:0] loaded;
      setMem(0, 0, 0, 0, 0, 0, 0, 0);
      idexValid = 1; idexOp = 6'd35; idexDest = 5'd5;
      ifidValid = 1; ifidInstr = {6'd0, 5'd5, 5'd7, 5'd6, 5'd0, 6'd32};
      #1;
      chk(stall == 1 && bubble == 1, "R7", {31'd0, stall}, 1);
      for (int c = 0; c < 4; c++) begin
        if (bubble) bubbles++;
        if (c == 0) begin
          // advance: load to MEM, bubble into EX, decode held
          step();
          idexValid = 0; idexOp = 0; idexDest = 0;
          setMem(1, 6'd35, 32'h40, 16'h0008, 0, 0, 5'd5, 0);
          #1;
        end else if (c == 1) begin
          step();
          loaded = memwbData;
          setMem(0, 0, 0, 0, 0, 0, 0, 0);
          ifidValid = 0;
          #1;
        end else begin
          step();
        end
      end
      chk(bubbles == 1, "R10", bubbles, 1);
      chk(loaded + r7 == 32'h12345678 + 32'd1000, "R10", loaded + r7, 32'h12345678 + 32'd1000);
    end

    // R10 branch in decode depending on load keeps delay slot in fetch
    begin
      logic [31:0] fetchSlot = 32'h00000000;
      logic [31:0] slotWord = 32'h2002_0001;
      idexValid = 1; idexOp = 6'd35; idexDest = 5'd8;
      ifidValid = 1; ifidInstr = {6'd4, 5'd8, 5'd9, 16'hFFF0};
      fetchSlot = slotWord;
      #1;
      chk(bubble == stall && stall == 1, "R10", {31'd0, stall}, 1);
      step();
      if (!stall) fetchSlot = 32'hFFFFFFFF;
      chk(fetchSlot == slotWord, "R10", fetchSlot, slotWord);
      idexValid = 0;
      #1;
      chk(stall == 0, "R10", {31'd0, stall}, 0);
    end

    // R8 rt compare only for some opcodes
    idexValid = 1; idexOp = 6'd35; idexDest = 5'd10; ifidValid = 1;
    ifidInstr = {6'd8, 5'd1, 5'd10, 16'd4}; #1;   // ADDI rt is a destination
    chk(stall == 0, "R8", {31'd0, stall}, 0);
    ifidInstr = {6'd43, 5'd1, 5'd10, 16'd4}; #1;  // SW reads rt
    chk(stall == 1, "R8", {31'd0, stall}, 1);
    ifidInstr = {6'd0, 5'd3, 5'd10, 5'd0, 5'd0, 6'd8}; #1; // JR ignores rt
    chk(stall == 0, "R8", {31'd0, stall}, 0);
    ifidInstr = {6'd0, 5'd10, 5'd0, 5'd0, 5'd0, 6'd8}; #1; // JR reads rs
    chk(stall == 1, "R7", {31'd0, stall}, 1);
    // R7 J and LUI read no rs
    ifidInstr = {6'd2, 5'd10, 21'd0}; #1;
    chk(stall == 0, "R7", {31'd0, stall}, 0);
    ifidInstr = {6'd15, 5'd10, 5'd2, 16'd1}; #1;
    chk(stall == 0, "R7", {31'd0, stall}, 0);
    // R9 dest zero and non-load
    idexDest = 5'd0; ifidInstr = {6'd0, 5'd0, 5'd0, 5'd1, 5'd0, 6'd32}; #1;
    chk(stall == 0, "R9", {31'd0, stall}, 0);
    idexDest = 5'd4; idexOp = 6'd43; ifidInstr = {6'd0, 5'd4, 5'd4, 5'd1, 5'd0, 6'd32}; #1;
    chk(stall == 0, "R9", {31'd0, stall}, 0);
    step();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ops [4] = '{6'd35, 6'd43, 6'd0, 6'd8};
      logic [5:0] dops [8] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd15, 6'd43};
      logic [31:0] ins;
      bit e;
      idexValid = 1'($urandom); idexOp = ops[$urandom % 4]; idexDest = 5'($urandom % 6);
      ifidValid = 1'($urandom);
      ins = $urandom;
      ins[31:26] = dops[$urandom % 8];
      ins[25:21] = 5'($urandom % 6); ins[20:16] = 5'($urandom % 6);
      if ($urandom % 2) ins[5:0] = ($urandom % 2) ? 6'd8 : 6'd9;
      ifidInstr = ins;
      #1;
      e = expStall(idexValid, idexOp, idexDest, ifidValid, ifidInstr);
      chk(stall == e && bubble == e, "R7", {31'd0, stall}, {31'd0, e});
      memOp(1'($urandom % 4 != 0), ops[$urandom % 4], 32'(($urandom % 16) * 4),
            16'(($urandom % 8) * 4 - 12), $urandom, $urandom, 5'($urandom % 4),
            1'($urandom), "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule